// File: doc/BRIEF.md
# PCM Time-Slot Channel Mapper

This block connects a framed serial PCM highway to up to 32 logical channel bit streams. For every highway bit it works out the bit position inside the current frame, from the frame sync pulse or from its own wrap-around. It then looks that position up in a per-slot assignment table. Receive and transmit each have their own table. Each slot entry names a channel, enables the slot, and carries an 8-bit mask, so a slot can be given to a channel whole or only in part.

Several slots, adjacent or not, may name the same channel; that channel then gets a wider pipe. On receive, selected bits come out tagged with their channel number. On transmit, the block asks for the next bit of the selected channel and drives it onto the line. Positions that are not selected are filled with 1, or released to high impedance.

Tables are written through a simple write port. A write goes to a pending copy. The pending copy is promoted to the active copy only at the next frame start, so a frame always uses one consistent map.

Top module: `pcm_slot_mapper`

## Requirements
- R1: A synchronous active-low reset clears both tables, so every slot is disabled. After reset, rx_valid=0, tx_data=1 and tx_oe=0.
- R2: A bit strobe (bit_en) with fsync high is bit 0 of slot 0. Each later strobe advances the position by one. After the last position of a frame, the next strobe is bit 0 of slot 0 even without fsync. Slot = position/8 and bit index = position%8, where bit index 0 is the first bit of the slot.
- R3: fmt selects the frame. fmt=0 (or 3) is 32 slots and 256 bits. fmt=1 is 24 slots and 192 bits. fmt=2 is 24 slots plus one framing bit at position 192, 193 bits in all. The framing bit belongs to no channel: rx_valid stays 0, and transmit treats it as an unselected bit.
- R4: A receive bit is selected when its slot entry is enabled and mask bit [bit index] is 1. One clock after the strobe, rx_valid=1, rx_chan = the entry's channel and rx_bit = the rx_data that was sampled.
- R5: A receive bit in a disabled slot, or at a mask position of 0, gives rx_valid=0.
- R6: For a selected transmit bit, tx_req_valid=1 and tx_req_chan = the entry's channel in the strobe cycle (combinational). One clock later, tx_data = tx_chan_bit as given in that cycle, and tx_oe=1.
- R7: For an unselected transmit bit, tx_data=1 one clock later. tx_oe=0 if idle_hiz=1 and tx_oe=1 otherwise. Whenever tx_oe=0, tx_data=1.
- R8: Any set of slots, adjacent or not, may carry the same channel number. Each of them steers bits to or from that channel.
- R9: cfg_dir=0 writes the receive table and cfg_dir=1 writes the transmit table. A write to one table leaves the other unchanged. An entry is written as cfg_en, cfg_chan[4:0] and cfg_mask[7:0] at index cfg_slot.
- R10: A table write takes effect at the first frame start (position 0) whose strobe comes in a later cycle than the write. The rest of the current frame uses the old map.
- R11: Outputs change only after strobe cycles. rx_valid is 1 for at most the one cycle after a strobe. tx_data and tx_oe hold their values while bit_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 2 | Frame format select (static) |
| idle_hiz | input | 1 | Unselected transmit bits are released (1) or driven high (0) |
| bit_en | input | 1 | One highway bit is processed this cycle |
| fsync | input | 1 | Marks bit 0 of slot 0, valid with bit_en |
| rx_data | input | 1 | Receive highway bit |
| rx_valid | output | 1 | A received bit was delivered to a channel |
| rx_chan | output | 5 | Channel of the delivered bit |
| rx_bit | output | 1 | Delivered bit value |
| tx_req_valid | output | 1 | The current transmit position belongs to a channel |
| tx_req_chan | output | 5 | Channel asked for its next bit |
| tx_chan_bit | input | 1 | Bit returned by the requested channel |
| tx_data | output | 1 | Transmit highway bit |
| tx_oe | output | 1 | Transmit output enable |
| cfg_we | input | 1 | Table write strobe |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_slot | input | 5 | Slot index to write |
| cfg_en | input | 1 | Slot enable value |
| cfg_chan | input | 5 | Channel number value |
| cfg_mask | input | 8 | Bit mask value |

## Verification
If the position counter is wrong, the very next strobe delivers a bit to the wrong channel, or fails to deliver one. The bench compares every strobe against its own model of position and tables, so the error shows within one bit. A table promoted too early or too late shows up on the first strobe that reaches a slot changed mid-frame. This is checked both before and after the frame boundary. A wrong framing-bit or idle-fill decision shows on tx_data or tx_oe one clock after the strobe concerned.

// File: rtl/pcm_map_pkg.sv
`timescale 1ns/1ps
// Shared layout for the slot mapper: the table entry and the frame format codes.
// Assumes channel numbers are 5 bits and each slot carries 8 bits.
package pcm_map_pkg;
    localparam int CH_W   = 5;
    localparam int MASK_W = 8;

    typedef struct packed {
        logic              en;
        logic [CH_W-1:0]   chan;
        logic [MASK_W-1:0] mask;
    } slot_ent_t;

    localparam int ENT_W = $bits(slot_ent_t);

    typedef enum logic [1:0] {
        FMT_32  = 2'd0,
        FMT_24  = 2'd1,
        FMT_24F = 2'd2,
        FMT_32B = 2'd3
    } frame_fmt_t;
endpackage

// File: rtl/pcm_bit_pos.sv
`timescale 1ns/1ps
// Tracks the position of the current highway bit within its frame.
// cur_pos is the position of the bit strobed in this cycle. It is 0 on fsync,
// or after the last position of the frame for the selected format.
// Assumes fmt is static between frame syncs.
module pcm_bit_pos
    import pcm_map_pkg::*;
#(
    parameter  int NSLOT       = 32,
    parameter  int SHORT_SLOTS = 24,
    localparam int FULL_LEN    = NSLOT * MASK_W,
    localparam int POS_W       = $clog2(FULL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  frame_fmt_t       fmt,
    input  logic             bit_en,
    input  logic             fsync,
    output logic [POS_W-1:0] cur_pos,
    output logic             frame_start,
    output logic             fbit
);
    localparam int SHORT_LEN = SHORT_SLOTS * MASK_W;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] last_pos;

    // Last position of a frame for the selected format
    always_comb begin
        unique case (fmt)
            FMT_24:  last_pos = POS_W'(SHORT_LEN - 1);
            FMT_24F: last_pos = POS_W'(SHORT_LEN);
            default: last_pos = POS_W'(FULL_LEN - 1);
        endcase
    end

    // Position of the bit strobed in this cycle
    always_comb begin
        if (fsync)
            cur_pos = '0;
        else if (pos_q == last_pos)
            cur_pos = '0;
        else
            cur_pos = pos_q + 1'b1;
    end

    assign frame_start = (cur_pos == '0);
    assign fbit        = (fmt == FMT_24F) && (cur_pos == POS_W'(SHORT_LEN));

    // Remember the last strobed position; reset parks it at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= last_pos;
        else if (bit_en)
            pos_q <= cur_pos;
    end
endmodule

// File: rtl/pcm_slot_table.sv
`timescale 1ns/1ps
// Double-buffered slot assignment table for one direction.
// Writes land in the pending copy. On commit, the whole pending copy becomes
// active. A read during a commit cycle returns the pending entry, so the
// first bit of a frame already uses the new map.
module pcm_slot_table
    import pcm_map_pkg::*;
#(
    parameter  int NSLOT  = 32,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SLOT_W-1:0]      wr_slot,
    input  slot_ent_t              wr_ent,
    input  logic                   commit,
    input  logic [SLOT_W-1:0]      rd_slot,
    output slot_ent_t              rd_ent,
    output logic [NSLOT*ENT_W-1:0] act_o
);
    slot_ent_t [NSLOT-1:0] pend_q;
    slot_ent_t [NSLOT-1:0] act_q;

    // Pending copy: cleared on reset, one entry written per write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else if (wr_en)
            pend_q[wr_slot] <= wr_ent;
    end

    // Active copy: replaced as a whole at a frame start
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (commit)
            act_q <= pend_q;
    end

    // Lookup for the current bit
    always_comb begin
        if (commit)
            rd_ent = pend_q[rd_slot];
        else
            rd_ent = act_q[rd_slot];
    end

    assign act_o = act_q;
endmodule

// File: rtl/pcm_lane_sel.sv
`timescale 1ns/1ps
// Decides whether the current bit belongs to a channel, from one table entry.
// Assumes bidx is the bit index inside the slot (0 = first bit).
module pcm_lane_sel
    import pcm_map_pkg::*;
#(
    localparam int BIT_W = $clog2(MASK_W)
) (
    input  logic            bit_en,
    input  logic            fbit,
    input  slot_ent_t       ent,
    input  logic [BIT_W-1:0] bidx,
    output logic            sel,
    output logic [CH_W-1:0] chan
);
    // A bit is taken when strobed, not framing, slot enabled and mask bit set
    always_comb begin
        sel  = bit_en && !fbit && ent.en && ent.mask[bidx];
        chan = ent.chan;
    end
endmodule

// File: rtl/pcm_slot_mapper.sv
`timescale 1ns/1ps
// Time-slot channel mapper for a framed serial PCM highway.
// Counts bit positions and looks up separate receive and transmit slot tables.
// Received bits go to a channel, and transmit bits are fetched from one.
// Assumes one highway bit per bit_en cycle, and that the transmit channel
// source answers tx_req_chan combinationally on tx_chan_bit.
module pcm_slot_mapper
    import pcm_map_pkg::*;
#(
    parameter  int NSLOT       = 32,
    parameter  int SHORT_SLOTS = 24,
    localparam int SLOT_W      = $clog2(NSLOT),
    localparam int BIT_W       = $clog2(MASK_W),
    localparam int POS_W       = $clog2(NSLOT * MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt,
    input  logic              idle_hiz,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              rx_data,
    output logic              rx_valid,
    output logic [CH_W-1:0]   rx_chan,
    output logic              rx_bit,
    output logic              tx_req_valid,
    output logic [CH_W-1:0]   tx_req_chan,
    input  logic              tx_chan_bit,
    output logic              tx_data,
    output logic              tx_oe,
    input  logic              cfg_we,
    input  logic              cfg_dir,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic              cfg_en,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [MASK_W-1:0] cfg_mask
);
    localparam int NDIR = 2;   // index 0 receive, 1 transmit

    logic [POS_W-1:0]       cur_pos;
    logic                   frame_start;
    logic                   fbit;
    logic                   commit;
    logic [SLOT_W-1:0]      cur_slot;
    logic [BIT_W-1:0]       cur_bidx;
    slot_ent_t              wr_ent;
    slot_ent_t              rd_ent   [NDIR];
    logic [NDIR-1:0]        lane_sel;
    logic [CH_W-1:0]        lane_ch  [NDIR];
    logic [NSLOT*ENT_W-1:0] act_flat [NDIR];
    logic [NSLOT*ENT_W-1:0] rx_act;
    logic [NSLOT*ENT_W-1:0] tx_act;

    pcm_bit_pos #(
        .NSLOT       (NSLOT),
        .SHORT_SLOTS (SHORT_SLOTS)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt         (frame_fmt_t'(fmt)),
        .bit_en      (bit_en),
        .fsync       (fsync),
        .cur_pos     (cur_pos),
        .frame_start (frame_start),
        .fbit        (fbit)
    );

    assign commit   = bit_en && frame_start;
    assign cur_slot = cur_pos[POS_W-1:BIT_W];
    assign cur_bidx = cur_pos[BIT_W-1:0];

    // Pack the write port fields into a table entry
    always_comb begin
        wr_ent.en   = cfg_en;
        wr_ent.chan = cfg_chan;
        wr_ent.mask = cfg_mask;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        pcm_slot_table #(
            .NSLOT (NSLOT)
        ) u_tab (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_dir == 1'(d))),
            .wr_slot (cfg_slot),
            .wr_ent  (wr_ent),
            .commit  (commit),
            .rd_slot (cur_slot),
            .rd_ent  (rd_ent[d]),
            .act_o   (act_flat[d])
        );

        pcm_lane_sel u_sel (
            .bit_en (bit_en),
            .fbit   (fbit),
            .ent    (rd_ent[d]),
            .bidx   (cur_bidx),
            .sel    (lane_sel[d]),
            .chan   (lane_ch[d])
        );
    end

    assign rx_act       = act_flat[0];
    assign tx_act       = act_flat[1];
    assign tx_req_valid = lane_sel[1];
    assign tx_req_chan  = lane_ch[1];

    // Receive delivery register: one pulse per selected bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_chan  <= '0;
            rx_bit   <= 1'b0;
        end else begin
            rx_valid <= lane_sel[0];
            if (lane_sel[0]) begin
                rx_chan <= lane_ch[0];
                rx_bit  <= rx_data;
            end
        end
    end

    // Transmit line register: channel bit when selected, idle fill otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data <= 1'b1;
            tx_oe   <= 1'b0;
        end else if (bit_en) begin
            tx_data <= lane_sel[1] ? tx_chan_bit : 1'b1;
            tx_oe   <= lane_sel[1] || !idle_hiz;
        end
    end
endmodule

// File: rtl/pcm_slot_mapper_chk.sv
`timescale 1ns/1ps
// Property checker for the slot mapper, attached by bind.
module pcm_slot_mapper_chk
    import pcm_map_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bit_en,
    input logic                   fsync,
    input logic                   frame_start,
    input logic                   fbit,
    input logic                   rx_valid,
    input logic                   tx_req_valid,
    input logic                   tx_data,
    input logic                   tx_oe,
    input logic [NSLOT*ENT_W-1:0] rx_act,
    input logic [NSLOT*ENT_W-1:0] tx_act
);
    // R11
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_en));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> ($stable(tx_data) && $stable(tx_oe)));

    // R3
    fbit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bit_en && fbit)) |-> (!rx_valid && tx_data));

    // R10
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en && frame_start)) |->
            ($stable(rx_act) && $stable(tx_act)));

    // R2
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync) |-> frame_start);

    // R7
    hiz_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_data);

    // R6
    req_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_valid |-> (bit_en && !fbit));
endmodule

bind pcm_slot_mapper pcm_slot_mapper_chk #(.NSLOT(NSLOT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .fsync        (fsync),
    .frame_start  (frame_start),
    .fbit         (fbit),
    .rx_valid     (rx_valid),
    .tx_req_valid (tx_req_valid),
    .tx_data      (tx_data),
    .tx_oe        (tx_oe),
    .rx_act       (rx_act),
    .tx_act       (tx_act)
);

// File: tb/pcm_slot_mapper_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed frames plus seeded random tables and traffic,
// compared against a bench-side model of position and both tables.
module pcm_slot_mapper_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] fmt;
    logic       idle_hiz, bit_en, fsync, rx_data;
    logic       rx_valid, rx_bit, tx_req_valid, tx_chan_bit, tx_data, tx_oe;
    logic [4:0] rx_chan, tx_req_chan;
    logic       cfg_we, cfg_dir, cfg_en;
    logic [4:0] cfg_slot, cfg_chan;
    logic [7:0] cfg_mask;
    logic [31:0] tx_src;

    int n_chk = 0;
    int n_bad = 0;
    string ph = "init";

    // model state
    logic [13:0] m_pend [2][32];
    logic [13:0] m_act  [2][32];
    int   m_pos;
    logic e_txd, e_txoe;

    always #2.5 clk = ~clk;

    assign tx_chan_bit = tx_src[tx_req_chan];

    pcm_slot_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .idle_hiz(idle_hiz),
        .bit_en(bit_en), .fsync(fsync), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_bit(rx_bit),
        .tx_req_valid(tx_req_valid), .tx_req_chan(tx_req_chan),
        .tx_chan_bit(tx_chan_bit), .tx_data(tx_data), .tx_oe(tx_oe),
        .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_slot(cfg_slot),
        .cfg_en(cfg_en), .cfg_chan(cfg_chan), .cfg_mask(cfg_mask)
    );

    function automatic int frame_last(input logic [1:0] f);
        if (f == 2'd1) return 191;
        if (f == 2'd2) return 192;
        return 255;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ph, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // One highway bit; starts and ends just after a falling edge
    task automatic do_bit(input bit fs, input bit rxd);
        int cur, slot, b;
        bit fb;
        bit s [2];
        int ch [2];
        logic [13:0] e;
        bit exp_rxv;
        int exp_rch;
        bit exp_rbit;
        string tg;
        bit_en = 1'b1; fsync = fs; rx_data = rxd;
        cur = fs ? 0 : ((m_pos == frame_last(fmt)) ? 0 : m_pos + 1);
        if (cur == 0) begin
            for (int d = 0; d < 2; d++)
                for (int k = 0; k < 32; k++) m_act[d][k] = m_pend[d][k];
        end
        fb = (fmt == 2'd2) && (cur == 192);
        slot = cur >> 3;
        b = cur & 7;
        for (int d = 0; d < 2; d++) begin
            e = m_act[d][slot];
            s[d] = !fb && e[13] && e[b];
            ch[d] = int'(e[12:8]);
        end
        #1;
        chk(tx_req_valid == s[1], "R6 req_valid", tx_req_valid, s[1]);
        if (s[1]) chk(tx_req_chan == ch[1][4:0], "R6 req_chan R8", tx_req_chan, ch[1]);
        exp_rxv = s[0]; exp_rch = ch[0]; exp_rbit = rxd;
        e_txd  = s[1] ? tx_src[ch[1]] : 1'b1;
        e_txoe = s[1] || !idle_hiz;
        m_pos = cur;
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
        tg = fb ? "R3 fbit rx" : (exp_rxv ? "R4 rx_valid" : "R5 rx ignored");
        chk(rx_valid == exp_rxv, tg, rx_valid, exp_rxv);
        if (exp_rxv) begin
            chk(rx_chan == exp_rch[4:0], "R4 R8 rx_chan", rx_chan, exp_rch);
            chk(rx_bit == exp_rbit, "R4 rx_bit", rx_bit, exp_rbit);
        end
        tg = fb ? "R3 fbit tx" : (s[1] ? "R6 tx_data" : "R7 tx idle fill");
        chk(tx_data == e_txd, tg, tx_data, e_txd);
        chk(tx_oe == e_txoe, tg, tx_oe, e_txoe);
    endtask

    task automatic idle_cyc();
        bit_en = 1'b0;
        @(negedge clk);
        chk(rx_valid == 1'b0, "R11 rx pulse", rx_valid, 0);
        chk(tx_data == e_txd && tx_oe == e_txoe, "R11 tx hold",
            {tx_data, tx_oe}, {e_txd, e_txoe});
    endtask

    task automatic cfg_wr(input bit dir, input int slot, input bit en,
                          input int chan, input int mask);
        cfg_we = 1'b1; cfg_dir = dir; cfg_slot = slot[4:0];
        cfg_en = en; cfg_chan = chan[4:0]; cfg_mask = mask[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        m_pend[dir][slot] = {en, chan[4:0], mask[7:0]};
        chk(rx_valid == 1'b0, "R9 R11 write cycle", rx_valid, 0);
    endtask

    task automatic run_bits(input int n, input bit sync_first, input bit gaps);
        for (int i = 0; i < n; i++) begin
            do_bit(sync_first && i == 0, 1'($urandom));
            if (gaps && ($urandom % 4 == 0)) idle_cyc();
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired [%s] actual=hung expected=done", ph);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fmt = 2'd0; idle_hiz = 1'b0; bit_en = 1'b0; fsync = 1'b0;
        rx_data = 1'b0; cfg_we = 1'b0; cfg_dir = 1'b0; cfg_slot = '0;
        cfg_en = 1'b0; cfg_chan = '0; cfg_mask = '0; tx_src = $urandom;
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < 32; k++) begin m_pend[d][k] = '0; m_act[d][k] = '0; end
        m_pos = 255; e_txd = 1'b1; e_txoe = 1'b0;
        repeat (3) @(negedge clk);
        ph = "R1 reset";
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(tx_data == 1'b1, "R1 tx_data", tx_data, 1);
        chk(tx_oe == 1'b0, "R1 tx_oe", tx_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);

        ph = "R1 empty tables";
        run_bits(256, 1'b1, 1'b0);

        ph = "R8 R9 directed map";
        cfg_wr(0, 3, 1, 5, 8'hFF);
        cfg_wr(0, 17, 1, 5, 8'hFF);
        cfg_wr(0, 20, 1, 9, 8'h01);
        cfg_wr(0, 31, 0, 7, 8'hFF);
        cfg_wr(1, 3, 1, 12, 8'hF0);
        cfg_wr(1, 8, 1, 5, 8'hFF);
        cfg_wr(1, 26, 1, 31, 8'h81);
        run_bits(512, 1'b1, 1'b1);

        ph = "R10 mid-frame write";
        run_bits(80, 1'b1, 1'b0);
        cfg_wr(0, 30, 1, 2, 8'hFF);
        cfg_wr(1, 29, 1, 3, 8'hAA);
        cfg_wr(0, 3, 0, 5, 8'hFF);
        run_bits(176 + 256, 1'b0, 1'b0);

        ph = "R3 24-slot frame";
        fmt = 2'd1;
        cfg_wr(0, 23, 1, 14, 8'hFF);
        cfg_wr(0, 0, 1, 15, 8'h80);
        cfg_wr(1, 23, 1, 16, 8'hFF);
        cfg_wr(1, 0, 1, 17, 8'hFF);
        run_bits(384, 1'b1, 1'b0);

        ph = "R3 framing bit";
        fmt = 2'd2;
        run_bits(3 * 193, 1'b1, 1'b1);

        ph = "R2 resync";
        fmt = 2'd0;
        run_bits(50, 1'b1, 1'b0);
        run_bits(300, 1'b1, 1'b0);

        ph = "R7 hiz idle";
        idle_hiz = 1'b1;
        run_bits(256, 1'b1, 1'b1);

        for (int r = 0; r < 6; r++) begin
            ph = "R8 R9 R10 random";
            fmt = 2'($urandom % 3);
            idle_hiz = 1'($urandom);
            tx_src = $urandom;
            for (int w = 0; w < 12; w++)
                cfg_wr(1'($urandom), int'($urandom % 32), ($urandom % 4) != 0,
                       int'($urandom % 32), int'($urandom % 256));
            run_bits(150, 1'b1, 1'b1);
            cfg_wr(1'($urandom), int'($urandom % 24), 1'b1,
                   int'($urandom % 32), int'($urandom % 256));
            run_bits(300, 1'b0, 1'b1);
        end

        summary();
        $finish;
    end
endmodule